// File: doc/BRIEF.md
# USB Host Fatal Error Reporter

This block sits beside the DMA engines of a USB 2.0 host controller and turns any abort of a memory read that the controller itself started into a fatal host error. Each read completion comes with a status code. A master abort or a target abort sets a sticky host-error status bit and a configuration status bit for that abort type. If system-error signalling is enabled, the abort also sets a signalled-system-error bit. The block then commands the DMA engines to halt.

The halt is deferred. If a USB transaction is in flight when the abort arrives, the engines may finish that one transaction, and the halt is raised after its done strobe. If nothing is in flight, the halt follows at once. Once raised, the halt stays up until reset. Software clears the status bits by writing 1 to them. The interrupt request is the host-error status gated by its enable, so clearing either the status or the enable removes the request.

Top module: `usb_fatal_err_rpt`

## Requirements
- R1: The completion code `rd_cpl_status` has four values: 2'b00 normal, 2'b01 master abort, 2'b10 target abort, 2'b11 reserved. A completion with a normal or reserved code never changes a status bit.
- R2: A valid master-abort or target-abort completion sets `host_err_sts` on the following cycle.
- R3: A master abort sets `rcv_mabort` and a target abort sets `rcv_tabort`, on the following cycle. Neither abort type sets the other type's bit.
- R4: An abort sets `sig_serr` on the following cycle only when `serr_en` is high during the abort cycle.
- R5: `irq` is high in every cycle in which both `host_err_sts` and `hse_irq_en` are high, and low in every other cycle.
- R6: If an abort arrives while the controller is running and either `xact_busy` is low or `xact_done` is high in that cycle, `dma_halt` rises on the next cycle.
- R7: If an abort arrives while the controller is running with `xact_busy` high and `xact_done` low, `dma_halt` rises on the cycle after the first later `xact_done` strobe, and not before.
- R8: Once `dma_halt` is high it stays high until reset. A further abort while a halt is pending or active does not restart the halt sequence, but it still sets the status bits for its abort type.
- R9: When `sts_wr` is high, each bit of `sts_wdata` that is 1 clears one status bit on the next cycle. The bit positions are: 0 `host_err_sts`, 1 `rcv_mabort`, 2 `rcv_tabort`, 3 `sig_serr`. A set and a clear of the same bit in the same cycle leave the bit set.
- R10: After a synchronous reset, all status bits, `irq` and `dma_halt` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_cpl_valid | input | 1 | A read completion is presented this cycle |
| rd_cpl_status | input | 2 | Completion code of that read |
| xact_busy | input | 1 | A USB transaction is in flight |
| xact_done | input | 1 | Strobe: a USB transaction completed |
| hse_irq_en | input | 1 | Host-error interrupt enable |
| serr_en | input | 1 | System-error signalling enable |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 4 | Write-1-to-clear mask |
| host_err_sts | output | 1 | Sticky host system error status |
| rcv_mabort | output | 1 | Received master abort status |
| rcv_tabort | output | 1 | Received target abort status |
| sig_serr | output | 1 | Signalled system error status |
| irq | output | 1 | Interrupt request |
| dma_halt | output | 1 | Halt command to the DMA engines |

## Verification
The hardest state to reach from the ports is the drain window: an abort has arrived while a transaction was in flight, and the halt is still waiting for that transaction's done strobe. It is harder still when a second abort or a status write lands inside that window. The random stimulus holds `xact_busy` high most of the time and pulses `xact_done` rarely, so drain windows last several cycles and often catch further aborts. Occasional resets return the controller to the running state, so the halt sequence is exercised many times. A directed case forces one long window and samples `dma_halt` on each cycle of it.

// File: rtl/usb_ferr_pkg.sv
package usb_ferr_pkg;

    typedef enum logic [1:0] {
        CPL_OK     = 2'b00,
        CPL_MABORT = 2'b01,
        CPL_TABORT = 2'b10,
        CPL_RSVD   = 2'b11
    } cpl_sts_e;

    typedef enum logic [1:0] {
        HC_RUN   = 2'b00,
        HC_DRAIN = 2'b01,
        HC_STOP  = 2'b10
    } halt_st_e;

    localparam int STS_W = 4;

    typedef struct packed {
        logic sse;
        logic rta;
        logic rma;
        logic hse;
    } err_sts_t;

    function automatic logic is_abort(cpl_sts_e s);
        return (s == CPL_MABORT) || (s == CPL_TABORT);
    endfunction

endpackage

// File: rtl/ferr_sts_bits.sv
module ferr_sts_bits #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    for (genvar k = 0; k < W; k++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst)
                bit_q <= 1'b0;
            else if (set_i[k])
                bit_q <= 1'b1;
            else if (clr_i[k])
                bit_q <= 1'b0;
        end
        assign q_o[k] = bit_q;

        p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
            set_i[k] |=> q_o[k]);
        p_hold_r9: assert property (@(posedge clk) disable iff (rst)
            (!set_i[k] && !clr_i[k]) |=> $stable(q_o[k]));
    end
endmodule

// File: rtl/ferr_halt_fsm.sv
module ferr_halt_fsm
    import usb_ferr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic abort_i,
    input  logic busy_i,
    input  logic done_i,
    output logic halt_o
);
    halt_st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        case (st_q)
            HC_RUN:   if (abort_i) st_d = (!busy_i || done_i) ? HC_STOP : HC_DRAIN;
            HC_DRAIN: if (done_i)  st_d = HC_STOP;
            HC_STOP:  st_d = HC_STOP;
            default:  st_d = HC_STOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= HC_RUN;
        else     st_q <= st_d;
    end

    assign halt_o = (st_q == HC_STOP);

    p_halt_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        halt_o |=> halt_o);
    p_idle_abort_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q == HC_RUN && abort_i && (!busy_i || done_i)) |=> halt_o);
    p_drain_done_r7: assert property (@(posedge clk) disable iff (rst)
        (st_q == HC_DRAIN && done_i) |=> halt_o);
    p_drain_wait_r7: assert property (@(posedge clk) disable iff (rst)
        (st_q == HC_DRAIN && !done_i) |=> !halt_o);
endmodule

// File: rtl/usb_fatal_err_rpt.sv
module usb_fatal_err_rpt
    import usb_ferr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_cpl_valid,
    input  logic [1:0] rd_cpl_status,
    input  logic       xact_busy,
    input  logic       xact_done,
    input  logic       hse_irq_en,
    input  logic       serr_en,
    input  logic       sts_wr,
    input  logic [3:0] sts_wdata,
    output logic       host_err_sts,
    output logic       rcv_mabort,
    output logic       rcv_tabort,
    output logic       sig_serr,
    output logic       irq,
    output logic       dma_halt
);
    cpl_sts_e code;
    logic     abort;
    err_sts_t set_v, clr_v, sts_q;

    assign code  = cpl_sts_e'(rd_cpl_status);
    assign abort = rd_cpl_valid && is_abort(code);

    always_comb begin
        set_v     = '0;
        set_v.hse = abort;
        set_v.rma = rd_cpl_valid && (code == CPL_MABORT);
        set_v.rta = rd_cpl_valid && (code == CPL_TABORT);
        set_v.sse = abort && serr_en;
        clr_v     = sts_wr ? err_sts_t'(sts_wdata) : '0;
    end

    ferr_sts_bits #(.W(STS_W)) u_sts (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_v),
        .clr_i (clr_v),
        .q_o   (sts_q)
    );

    ferr_halt_fsm u_halt (
        .clk     (clk),
        .rst     (rst),
        .abort_i (abort),
        .busy_i  (xact_busy),
        .done_i  (xact_done),
        .halt_o  (dma_halt)
    );

    assign host_err_sts = sts_q.hse;
    assign rcv_mabort   = sts_q.rma;
    assign rcv_tabort   = sts_q.rta;
    assign sig_serr     = sts_q.sse;
    assign irq          = sts_q.hse && hse_irq_en;

    p_normal_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (!abort && !sts_wr) |=> $stable({host_err_sts, rcv_mabort, rcv_tabort, sig_serr}));
    p_abort_sets_r2: assert property (@(posedge clk) disable iff (rst)
        abort |=> host_err_sts);
    p_serr_gate_r4: assert property (@(posedge clk) disable iff (rst)
        (abort && !serr_en && !sig_serr) |=> !sig_serr);
    p_type_split_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_cpl_valid && code == CPL_MABORT && !rcv_tabort) |=> !rcv_tabort);
endmodule

// File: tb/usb_fatal_err_rpt_tb_top.sv
module usb_fatal_err_rpt_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rd_cpl_valid = 0, xact_busy = 0, xact_done = 0;
    logic hse_irq_en = 0, serr_en = 0, sts_wr = 0;
    logic [1:0] rd_cpl_status = 0;
    logic [3:0] sts_wdata = 0;
    logic host_err_sts, rcv_mabort, rcv_tabort, sig_serr, irq, dma_halt;

    int n_chk = 0, n_bad = 0;
    logic [3:0] m_sts;
    int m_st;   // 0 run, 1 drain, 2 stopped

    always #2 clk = ~clk;

    usb_fatal_err_rpt dut_i (
        .clk(clk), .rst(rst), .rd_cpl_valid(rd_cpl_valid), .rd_cpl_status(rd_cpl_status),
        .xact_busy(xact_busy), .xact_done(xact_done), .hse_irq_en(hse_irq_en),
        .serr_en(serr_en), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
        .host_err_sts(host_err_sts), .rcv_mabort(rcv_mabort), .rcv_tabort(rcv_tabort),
        .sig_serr(sig_serr), .irq(irq), .dma_halt(dma_halt)
    );

    task automatic chk(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] next_sts(logic [3:0] s, logic v, logic [1:0] c,
                                            logic se, logic wr, logic [3:0] wd);
        logic [3:0] setv, n;
        logic ab = v && (c == 2'b01 || c == 2'b10);
        setv = {ab && se, v && c == 2'b10, v && c == 2'b01, ab};
        n = s & ~(wr ? wd : 4'b0);
        return n | setv;
    endfunction

    function automatic int next_st(int st, logic v, logic [1:0] c, logic b, logic d);
        logic ab = v && (c == 2'b01 || c == 2'b10);
        if (st == 0 && ab) return (!b || d) ? 2 : 1;
        if (st == 1 && d) return 2;
        return st;
    endfunction

    // Compare all outputs against the model (called at negedge)
    task automatic check_all();
        chk("R2", "host_err_sts", host_err_sts, m_sts[0]);
        chk("R3", "rcv_mabort", rcv_mabort, m_sts[1]);
        chk("R3", "rcv_tabort", rcv_tabort, m_sts[2]);
        chk("R4", "sig_serr", sig_serr, m_sts[3]);
        chk("R5", "irq", irq, m_sts[0] && hse_irq_en);
        chk(m_st == 1 ? "R7" : "R6", "dma_halt", dma_halt, m_st == 2);
    endtask

    // Apply inputs for one cycle, advance model, wait to next negedge
    task automatic step(logic r, logic v, logic [1:0] c, logic b, logic d,
                        logic ie, logic se, logic wr, logic [3:0] wd);
        rst = r; rd_cpl_valid = v; rd_cpl_status = c; xact_busy = b; xact_done = d;
        hse_irq_en = ie; serr_en = se; sts_wr = wr; sts_wdata = wd;
        if (r) begin
            m_sts = 4'b0; m_st = 0;
        end else begin
            m_sts = next_sts(m_sts, v, c, se, wr, wd);
            m_st  = next_st(m_st, v, c, b, d);
        end
        @(negedge clk);
        check_all();
    endtask

    initial begin
        #800000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        m_sts = 0; m_st = 0;
        @(negedge clk);
        step(1, 0, 0, 0, 0, 1, 1, 0, 0);
        // R10: reset state
        chk("R10", "reset host_err_sts", host_err_sts, 0);
        chk("R10", "reset dma_halt", dma_halt, 0);
        chk("R10", "reset irq", irq, 0);
        // R1: normal and reserved codes change nothing
        step(0, 1, 2'b00, 0, 0, 1, 1, 0, 0);
        step(0, 1, 2'b11, 0, 0, 1, 1, 0, 0);
        chk("R1", "no status after normal/reserved", host_err_sts | rcv_mabort | rcv_tabort | sig_serr, 0);
        // R7: target abort while busy, long drain
        step(0, 1, 2'b10, 1, 0, 1, 0, 0, 0);
        chk("R3", "tabort only", {rcv_mabort, rcv_tabort}, 2'b01);
        chk("R4", "serr gated off", sig_serr, 0);
        for (int i = 0; i < 5; i++) begin
            step(0, (i == 2), 2'b01, 1, 0, 1, 0, 0, 0);
            chk("R7", "no halt while draining", dma_halt, 0);
        end
        chk("R8", "second abort still sets mabort", rcv_mabort, 1);
        step(0, 0, 0, 1, 1, 1, 0, 0, 0);
        chk("R7", "halt after done", dma_halt, 1);
        // R9: clear with simultaneous set; halt survives clears
        step(0, 1, 2'b01, 0, 0, 1, 1, 1, 4'b1111);
        chk("R9", "set wins over clear", rcv_mabort, 1);
        chk("R9", "tabort cleared", rcv_tabort, 0);
        step(0, 0, 0, 0, 0, 1, 0, 1, 4'b0001);
        chk("R5", "irq drops on clear", irq, 0);
        chk("R8", "halt held", dma_halt, 1);
        // R6: idle abort after reset
        step(1, 0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 1, 2'b01, 0, 0, 0, 1, 0, 0);
        chk("R6", "immediate halt", dma_halt, 1);
        chk("R4", "serr set", sig_serr, 1);
        // Random phase
        for (int n = 0; n < 4000; n++) begin
            logic r = ($urandom_range(0, 59) == 0);
            logic v = ($urandom_range(0, 3) == 0);
            logic [1:0] c = 2'($urandom_range(0, 3));
            logic b = ($urandom_range(0, 4) != 0);
            logic d = ($urandom_range(0, 5) == 0);
            logic ie = ($urandom_range(0, 3) != 0);
            logic se = $urandom_range(0, 1) == 1;
            logic wr = ($urandom_range(0, 7) == 0);
            logic [3:0] wd = 4'($urandom_range(0, 15));
            step(r, v, c, b, d, ie, se, wr, wd);
        end
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule